// File: doc/BRIEF.md
# Confirmed-Taken Branch Direction Predictor

This block is a direct-mapped table that remembers, per branch, whether it was last seen taken and whether that guess has since been borne out. The fetch stage presents an instruction address and gets back a taken or not-taken guess in the same cycle. When the branch later resolves, the resolve side presents the same address, the real outcome and the guess that was used. The matching entry is then updated, and a one-cycle mispredict pulse tells the pipeline to go back to the path it was on before the guess.

Each entry is a small state machine with four named states. ST_EMPTY is an entry that holds no branch. ST_NOT_TAKEN has prediction bit clear. ST_TAKEN has prediction bit set and confirmation bit clear. ST_CONFIRMED has both bits set. These are the transitions on a resolve whose tag matches. From ST_NOT_TAKEN, a taken outcome goes to ST_TAKEN and a not-taken outcome stays put. From ST_TAKEN, a taken outcome goes to ST_CONFIRMED. From ST_CONFIRMED, a taken outcome stays put. From either taken state, a not-taken outcome clears both bits and goes to ST_NOT_TAKEN. On a resolve that finds ST_EMPTY or a tag mismatch, the entry is installed: it goes to ST_TAKEN or ST_NOT_TAKEN according to the outcome, and the new tag is stored. Synchronous reset returns every entry to ST_EMPTY.

Top module: `branch_confirm_predictor`

## Requirements
- R1: After synchronous reset every entry is empty, and the fetch guess is not-taken (0) for every address.
- R2: A fetch that hits an empty entry or an entry with a different tag predicts not-taken. The first resolve of a branch installs it, predicting taken exactly when its outcome was taken.
- R3: A resolve with outcome taken, hitting an ST_TAKEN entry, moves it to ST_CONFIRMED, which predicts taken.
- R4: A resolve with outcome taken, hitting an ST_CONFIRMED entry, leaves it predicting taken.
- R5: A resolve with outcome not-taken, hitting an ST_TAKEN or ST_CONFIRMED entry, moves it to ST_NOT_TAKEN, which predicts not-taken.
- R6: In ST_NOT_TAKEN, a resolve with outcome not-taken keeps the guess not-taken, and a resolve with outcome taken moves the entry to ST_TAKEN, which predicts taken.
- R7: The entry index is address bits [5:2] and the tag is bits [ADDR_W-1:6]. Bits [1:0] do not affect the guess. A resolve whose tag mismatches replaces the entry, after which the old branch predicts not-taken.
- R8: A fetch and a resolve to the same index in the same cycle return the state from before the update. The update is seen from the next cycle.
- R9: `mispredict_o` is 1 in the cycle after a resolve whose used guess differs from its outcome, and 0 after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_addr | input | ADDR_W | Fetch-side branch address |
| fe_pred_taken | output | 1 | Guess for fe_addr, 1 = taken |
| rs_valid | input | 1 | Resolve request this cycle |
| rs_addr | input | ADDR_W | Address of the resolving branch |
| rs_taken | input | 1 | Real outcome, 1 = taken |
| rs_pred_used | input | 1 | Guess the pipeline followed |
| mispredict_o | output | 1 | Registered pulse: guess was wrong |

## Verification
The bench goes after the reversal rule. A design that let a confirmed entry survive one not-taken outcome, as a saturating counter would, keeps predicting taken after R5's miss. It also aims at aliasing between two addresses that share an index: a design that skipped the tag compare would return the old branch's guess for the new one. The same-cycle read and update case catches a bypassed table, which would show the new guess one cycle early. The mispredict pulse is checked on both a wrong and a right guess, so an inverted or unregistered pulse shows up.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY     = 2'd0,
        ST_NOT_TAKEN = 2'd1,
        ST_TAKEN     = 2'd2,
        ST_CONFIRMED = 2'd3
    } bp_state_e;

    function automatic logic state_says_taken(input bp_state_e s);
        return (s == ST_TAKEN) || (s == ST_CONFIRMED);
    endfunction

endpackage

// File: rtl/bp_addr_split.sv
module bp_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    logic unused_low;

    assign idx        = addr[OFF_W +: IDX_W];
    assign tag        = addr[ADDR_W-1 -: TAG_W];
    assign unused_low = ^addr[OFF_W-1:0];
endmodule

// File: rtl/bp_entry.sv
module bp_entry
    import bp_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_taken,
    output bp_state_e        state_o,
    output logic [TAG_W-1:0] tag_o
);
    bp_state_e        state_q, state_d;
    logic [TAG_W-1:0] tag_q;
    logic             hit;

    assign hit = (state_q != ST_EMPTY) && (tag_q == wr_tag);

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (!hit) begin
                state_d = wr_taken ? ST_TAKEN : ST_NOT_TAKEN;
            end else begin
                unique case (state_q)
                    ST_NOT_TAKEN: state_d = wr_taken ? ST_TAKEN     : ST_NOT_TAKEN;
                    ST_TAKEN:     state_d = wr_taken ? ST_CONFIRMED : ST_NOT_TAKEN;
                    ST_CONFIRMED: state_d = wr_taken ? ST_CONFIRMED : ST_NOT_TAKEN;
                    default:      state_d = wr_taken ? ST_TAKEN     : ST_NOT_TAKEN;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wr_en && !hit) tag_q <= wr_tag;
        end
    end

    assign state_o = state_q;
    assign tag_o   = tag_q;

    // R1
    reset_empty_chk: assert property (@(posedge clk) rst |=> state_q == ST_EMPTY);

    // R3
    confirm_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit && wr_taken && state_q == ST_TAKEN) |=> state_q == ST_CONFIRMED);

    // R5
    miss_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit && !wr_taken) |=> state_q == ST_NOT_TAKEN);

    // R4
    confirmed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONFIRMED && !(wr_en && !wr_taken) && !(wr_en && !hit))
        |=> state_q == ST_CONFIRMED);

    // R7
    tag_install_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit) |=> (tag_q == $past(wr_tag)) && (state_q != ST_EMPTY));
endmodule

// File: rtl/branch_confirm_predictor.sv
module branch_confirm_predictor
    import bp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    localparam int OFF_W   = 2,
    localparam int ENTRIES = 1 << IDX_W,
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fe_addr,
    output logic              fe_pred_taken,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_addr,
    input  logic              rs_taken,
    input  logic              rs_pred_used,
    output logic              mispredict_o
);
    logic [IDX_W-1:0] fe_idx, rs_idx;
    logic [TAG_W-1:0] fe_tag, rs_tag;
    bp_state_e        ent_state [ENTRIES];
    logic [TAG_W-1:0] ent_tag   [ENTRIES];
    bp_state_e        fe_state;
    logic             fe_hit;
    logic             mispredict_q;

    bp_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_fe_split (
        .addr (fe_addr),
        .idx  (fe_idx),
        .tag  (fe_tag)
    );

    bp_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_rs_split (
        .addr (rs_addr),
        .idx  (rs_idx),
        .tag  (rs_tag)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        bp_entry #(.TAG_W(TAG_W)) u_entry (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (rs_valid && (rs_idx == IDX_W'(i))),
            .wr_tag   (rs_tag),
            .wr_taken (rs_taken),
            .state_o  (ent_state[i]),
            .tag_o    (ent_tag[i])
        );
    end

    assign fe_state      = ent_state[fe_idx];
    assign fe_hit        = (fe_state != ST_EMPTY) && (ent_tag[fe_idx] == fe_tag);
    assign fe_pred_taken = fe_hit && state_says_taken(fe_state);

    always_ff @(posedge clk) begin
        if (rst) mispredict_q <= 1'b0;
        else     mispredict_q <= rs_valid && (rs_pred_used != rs_taken);
    end

    assign mispredict_o = mispredict_q;

    // R9
    mispredict_src_chk: assert property (@(posedge clk) disable iff (rst)
        mispredict_o |-> $past(rs_valid));

    // R2
    empty_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (fe_state == ST_EMPTY) |-> !fe_pred_taken);
endmodule

// File: tb/branch_confirm_predictor_bench.sv
module branch_confirm_predictor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] fe_addr;
    logic              fe_pred_taken;
    logic              rs_valid;
    logic [ADDR_W-1:0] rs_addr;
    logic              rs_taken;
    logic              rs_pred_used;
    logic              mispredict_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_confirm_predictor #(.ADDR_W(ADDR_W), .IDX_W(4)) u_branch_confirm_predictor (
        .clk           (clk),
        .rst           (rst),
        .fe_addr       (fe_addr),
        .fe_pred_taken (fe_pred_taken),
        .rs_valid      (rs_valid),
        .rs_addr       (rs_addr),
        .rs_taken      (rs_taken),
        .rs_pred_used  (rs_pred_used),
        .mispredict_o  (mispredict_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic expect_pred(input string req, input logic [ADDR_W-1:0] a, input logic exp);
        fe_addr = a;
        #1;
        check(req, fe_pred_taken, exp);
    endtask

    // drive at negedge, update on posedge, return at the next negedge
    task automatic resolve(input logic [ADDR_W-1:0] a, input logic taken,
                           input logic used, output logic mp);
        rs_valid     = 1'b1;
        rs_addr      = a;
        rs_taken     = taken;
        rs_pred_used = used;
        @(posedge clk);
        @(negedge clk);
        rs_valid = 1'b0;
        mp = mispredict_o;
    endtask

    task automatic t_reset();
        logic mp;
        rst = 1'b1; rs_valid = 1'b0; rs_addr = '0; rs_taken = 1'b0;
        rs_pred_used = 1'b0; fe_addr = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        expect_pred("R1", 32'h0000_0000, 1'b0);
        expect_pred("R1", 32'h0000_0044, 1'b0);
        expect_pred("R1", 32'hFFFF_FFFC, 1'b0);
        check("R9", mispredict_o, 1'b0);
        mp = 1'b0;
    endtask

    task automatic t_install();
        logic mp;
        resolve(32'h44, 1'b1, 1'b0, mp);
        check("R9", mp, 1'b1);
        expect_pred("R2", 32'h44, 1'b1);
        resolve(32'h48, 1'b0, 1'b0, mp);
        check("R9", mp, 1'b0);
        expect_pred("R2", 32'h48, 1'b0);
    endtask

    task automatic t_confirm_and_break();
        logic mp;
        resolve(32'h44, 1'b1, 1'b1, mp);
        check("R9", mp, 1'b0);
        expect_pred("R3", 32'h44, 1'b1);
        resolve(32'h44, 1'b1, 1'b1, mp);
        expect_pred("R4", 32'h44, 1'b1);
        resolve(32'h44, 1'b0, 1'b1, mp);
        check("R9", mp, 1'b1);
        expect_pred("R5", 32'h44, 1'b0);
    endtask

    task automatic t_not_taken_state();
        logic mp;
        resolve(32'h48, 1'b0, 1'b0, mp);
        expect_pred("R6", 32'h48, 1'b0);
        resolve(32'h48, 1'b1, 1'b0, mp);
        expect_pred("R6", 32'h48, 1'b1);
        resolve(32'h48, 1'b0, 1'b1, mp);
        expect_pred("R5", 32'h48, 1'b0);
    endtask

    task automatic t_alias();
        logic mp;
        resolve(32'h100, 1'b1, 1'b0, mp);
        expect_pred("R7", 32'h100, 1'b1);
        expect_pred("R7", 32'h103, 1'b1);
        expect_pred("R7", 32'h200, 1'b0);
        resolve(32'h200, 1'b1, 1'b0, mp);
        expect_pred("R7", 32'h200, 1'b1);
        resolve(32'h200, 1'b0, 1'b1, mp);
        expect_pred("R7", 32'h200, 1'b0);
        resolve(32'h100, 1'b1, 1'b0, mp);
        expect_pred("R7", 32'h200, 1'b0);
        expect_pred("R7", 32'h100, 1'b1);
    endtask

    task automatic t_same_cycle();
        fe_addr      = 32'h0C;
        rs_valid     = 1'b1;
        rs_addr      = 32'h0C;
        rs_taken     = 1'b1;
        rs_pred_used = 1'b0;
        #1;
        check("R8", fe_pred_taken, 1'b0);
        @(posedge clk);
        @(negedge clk);
        rs_valid = 1'b0;
        #1;
        check("R8", fe_pred_taken, 1'b1);
    endtask

    initial begin
        t_reset();
        t_install();
        t_confirm_and_break();
        t_not_taken_state();
        t_alias();
        t_same_cycle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule